// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a three-wire serial audio stream (bit clock, word clock, serial data) into a single system clock domain. It recovers one stereo sample pair per word-clock period. All three wires pass through synchronizers. A rising edge of the synchronized bit clock marks one bit slot, and the serial data and word clock are sampled in that slot. A change of word-clock level between two slots ends one channel half-period and starts the next.

A static format code picks how the bits of a half-period map onto the sample:
- MSB-aligned with no delay.
- MSB-aligned after one slot of delay.
- LSB-aligned, with a word length of 16, 18, 20 or 24 bits. Slots ahead of the word are ignored.

Each finished half-period gives a 24-bit sign-extended sample, a channel indicator and a one-cycle valid strobe. A half-period with fewer slots than the minimum for the format gives a one-cycle framing-error strobe instead.

Top module: `audio_serial_rx`

## Requirements
- R1: In the cycle after synchronous reset is applied, valid_o, frame_err_o, chan_o and sample_o are all zero.
- R2: Format code 0 (MSB-aligned). Slot 0 after a word-clock change carries the sample MSB, and slots 0 to 23 carry bits 23 down to 0. Later slots are ignored. Word clock high is the left channel.
- R3: Format code 1 (delayed). Slot 0 is ignored, and slots 1 to 24 carry bits 23 down to 0. Later slots are ignored. Word clock low is the left channel.
- R4: Format codes 2, 3, 4 and 5 are LSB-aligned with word lengths of 16, 24, 20 and 18 bits. The last slot before the next word-clock change is the LSB. Slots ahead of the word are ignored. Word clock high is the left channel.
- R5: In the LSB-aligned formats, sample bits above the word length copy the word's top bit.
- R6: A half-period is reported only when the next word-clock change arrives. The report is a valid_o pulse of exactly one cycle, with chan_o set to 0 for left and 1 for right. The partial half-period that ends at the first change after reset is never reported. sample_o changes only together with valid_o.
- R7: The minimum slot count per half-period is 24, 25, 16, 24, 20 and 18 for format codes 0 to 5. A shorter half-period raises frame_err_o for one cycle and does not raise valid_o, and the two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be at least four times the bit-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 3 | Static format code, 0 to 5 |
| bclk_i | input | 1 | Serial bit clock; data is sampled on its rising edge |
| wclk_i | input | 1 | Word (channel) clock |
| sdata_i | input | 1 | Serial data, MSB first |
| sample_o | output | 24 | Last received sample, sign-extended |
| chan_o | output | 1 | Channel of sample_o: 0 left, 1 right |
| valid_o | output | 1 | One-cycle strobe: new sample on sample_o |
| frame_err_o | output | 1 | One-cycle strobe: half-period too short |

## Verification
A slot counter or alignment index that is off by one shows up in the very next report. The sample comes out shifted by one bit, or the error strobe fires on a half-period of exactly the minimum length. A wrong channel decode or an unprimed word-clock history shows up as a wrong chan_o on the first reported half-period, or as an extra report straight after reset. Every half-period is reported two system cycles after the first slot of the next half-period, so each fault is visible within one half-period of its cause.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int CNT_W    = 6;

    typedef enum logic [2:0] {
        FMT_MSB   = 3'd0,
        FMT_DLY   = 3'd1,
        FMT_LSB16 = 3'd2,
        FMT_LSB24 = 3'd3,
        FMT_LSB20 = 3'd4,
        FMT_LSB18 = 3'd5
    } fmt_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] data;
        logic                chan;
    } smp_t;

    function automatic logic is_lsb_fmt(fmt_e f);
        return (f == FMT_LSB16) || (f == FMT_LSB24) ||
               (f == FMT_LSB20) || (f == FMT_LSB18);
    endfunction

    function automatic int word_len(fmt_e f);
        case (f)
            FMT_LSB16: return 16;
            FMT_LSB20: return 20;
            FMT_LSB18: return 18;
            default:   return 24;
        endcase
    endfunction

    function automatic int half_min(fmt_e f);
        case (f)
            FMT_DLY:   return 25;
            FMT_LSB16: return 16;
            FMT_LSB20: return 20;
            FMT_LSB18: return 18;
            default:   return 24;
        endcase
    endfunction

    // Left channel: word clock low for the delayed format, high otherwise.
    function automatic logic chan_of(fmt_e f, logic level);
        return (f == FMT_DLY) ? level : ~level;
    endfunction

    function automatic logic [SAMPLE_W-1:0] sext(logic [SAMPLE_W-1:0] v, int w);
        logic [SAMPLE_W-1:0] r;
        for (int i = 0; i < SAMPLE_W; i++)
            r[i] = (i < w) ? v[i] : v[w-1];
        return r;
    endfunction

    function automatic logic [SAMPLE_W-1:0] place_bit(
        logic [SAMPLE_W-1:0] acc, int idx, logic b, fmt_e f);
        logic [SAMPLE_W-1:0] r;
        int                  off;
        r   = acc;
        off = (f == FMT_DLY) ? 1 : 0;
        if (idx >= off && idx < off + SAMPLE_W)
            r[SAMPLE_W-1-(idx-off)] = b;
        return r;
    endfunction

endpackage

// File: rtl/aud_sync.sv
module aud_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= '0;
                else if (s == 0)
                    chain[s] <= d_i;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/aud_deser.sv
module aud_deser
    import aud_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_stb_i,
    input  logic                wclk_i,
    input  logic                sd_i,
    input  fmt_e                fmt_i,
    output logic                done_o,
    output logic                level_o,
    output logic [CNT_W-1:0]    half_cnt_o,
    output logic [SAMPLE_W-1:0] word_o
);
    logic [SAMPLE_W-1:0] acc;
    logic [SAMPLE_W-1:0] sh;
    logic [CNT_W-1:0]    cnt;
    logic                prev_w;
    logic                primed;
    logic                started;
    logic                change;
    logic [SAMPLE_W-1:0] sh_next;

    assign change  = primed && (wclk_i != prev_w);
    assign sh_next = {sh[SAMPLE_W-2:0], sd_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            sh         <= '0;
            cnt        <= '0;
            prev_w     <= 1'b0;
            primed     <= 1'b0;
            started    <= 1'b0;
            done_o     <= 1'b0;
            level_o    <= 1'b0;
            half_cnt_o <= '0;
            word_o     <= '0;
        end else begin
            done_o <= 1'b0;
            if (bit_stb_i) begin
                primed <= 1'b1;
                prev_w <= wclk_i;
                sh     <= sh_next;
                if (change) begin
                    done_o     <= started;
                    started    <= 1'b1;
                    level_o    <= prev_w;
                    half_cnt_o <= cnt;
                    word_o     <= is_lsb_fmt(fmt_i) ? sext(sh, word_len(fmt_i)) : acc;
                    acc        <= place_bit('0, 0, sd_i, fmt_i);
                    cnt        <= CNT_W'(1);
                end else begin
                    acc <= place_bit(acc, int'(cnt), sd_i, fmt_i);
                    if (cnt != '1)
                        cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/aud_frame_chk.sv
module aud_frame_chk
    import aud_rx_pkg::*;
(
    input  fmt_e             fmt_i,
    input  logic [CNT_W-1:0] half_cnt_i,
    output logic             short_o
);
    always_comb short_o = int'(half_cnt_i) < half_min(fmt_i);
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import aud_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          fmt_i,
    input  logic                bclk_i,
    input  logic                wclk_i,
    input  logic                sdata_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                chan_o,
    output logic                valid_o,
    output logic                frame_err_o
);
    fmt_e                fmt;
    logic [2:0]          sync_q;
    logic                bclk_prev;
    logic                bit_stb;
    logic                done;
    logic                level;
    logic [CNT_W-1:0]    half_cnt;
    logic [SAMPLE_W-1:0] word;
    logic                short_half;
    smp_t                nxt;

    assign fmt = fmt_e'(fmt_i);

    aud_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({bclk_i, wclk_i, sdata_i}),
        .q_o (sync_q)
    );

    always_ff @(posedge clk) begin
        if (rst) bclk_prev <= 1'b0;
        else     bclk_prev <= sync_q[2];
    end

    assign bit_stb = sync_q[2] & ~bclk_prev;

    aud_deser u_deser (
        .clk        (clk),
        .rst        (rst),
        .bit_stb_i  (bit_stb),
        .wclk_i     (sync_q[1]),
        .sd_i       (sync_q[0]),
        .fmt_i      (fmt),
        .done_o     (done),
        .level_o    (level),
        .half_cnt_o (half_cnt),
        .word_o     (word)
    );

    aud_frame_chk u_frame (
        .fmt_i      (fmt),
        .half_cnt_i (half_cnt),
        .short_o    (short_half)
    );

    assign nxt.data = word;
    assign nxt.chan = chan_of(fmt, level);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o     <= 1'b0;
            frame_err_o <= 1'b0;
            sample_o    <= '0;
            chan_o      <= 1'b0;
        end else begin
            valid_o     <= done & ~short_half;
            frame_err_o <= done &  short_half;
            if (done && !short_half) begin
                sample_o <= nxt.data;
                chan_o   <= nxt.chan;
            end
        end
    end
endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  fmt_i,
    input logic [23:0] sample_o,
    input logic        chan_o,
    input logic        valid_o,
    input logic        frame_err_o
);
    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always_ff @(posedge clk)
        if (rst_q)
            reset_state_chk: assert (!valid_o && !frame_err_o && !chan_o && sample_o == 24'd0);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R6
    sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sample_o) |-> valid_o);

    // R7
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && frame_err_o));

    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |=> !frame_err_o);

    // R5
    sext16_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && fmt_i == 3'd2) |-> (sample_o[23:16] == {8{sample_o[15]}}));

    // R5
    sext18_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && fmt_i == 3'd5) |-> (sample_o[23:18] == {6{sample_o[17]}}));

    // R5
    sext20_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && fmt_i == 3'd4) |-> (sample_o[23:20] == {4{sample_o[19]}}));
endmodule

bind audio_serial_rx aud_rx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fmt_i       (fmt_i),
    .sample_o    (sample_o),
    .chan_o      (chan_o),
    .valid_o     (valid_o),
    .frame_err_o (frame_err_o)
);

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  fmt_i = 3'd0;
    logic        bclk_i = 1'b0;
    logic        wclk_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic [23:0] sample_o;
    logic        chan_o;
    logic        valid_o;
    logic        frame_err_o;

    int n_tests = 0;
    int n_fail  = 0;
    int n_exp   = 0;
    int n_got   = 0;
    logic [23:0] exp_data [256];
    logic        exp_chan [256];
    logic        exp_err  [256];

    always #2 clk = ~clk;

    audio_serial_rx u_dut (
        .clk(clk), .rst(rst), .fmt_i(fmt_i), .bclk_i(bclk_i), .wclk_i(wclk_i),
        .sdata_i(sdata_i), .sample_o(sample_o), .chan_o(chan_o),
        .valid_o(valid_o), .frame_err_o(frame_err_o)
    );

    function automatic int wlen(int f);
        case (f)
            2: return 16; 3: return 24; 4: return 20; 5: return 18;
            default: return 24;
        endcase
    endfunction

    function automatic int hmin(int f);
        case (f)
            1: return 25; 2: return 16; 3: return 24; 4: return 20; 5: return 18;
            default: return 24;
        endcase
    endfunction

    // Monitor: every report compared in order against the expected list.
    always @(negedge clk) begin
        if (!rst && (valid_o || frame_err_o)) begin
            n_tests++;
            if (n_got >= n_exp) begin
                n_fail++;
                $display("FAIL R6: unexpected report #%0d, valid=%0b err=%0b, expected none",
                         n_got, valid_o, frame_err_o);
            end else if (exp_err[n_got]) begin
                if (!frame_err_o || valid_o) begin
                    n_fail++;
                    $display("FAIL R7: report #%0d valid=%0b err=%0b, expected err=1 valid=0",
                             n_got, valid_o, frame_err_o);
                end
            end else if (!valid_o || sample_o != exp_data[n_got] || chan_o != exp_chan[n_got]) begin
                n_fail++;
                $display("FAIL R2/R3/R4/R5/R6 (fmt %0d): report #%0d valid=%0b data=%h chan=%0b, expected valid=1 data=%h chan=%0b",
                         fmt_i, n_got, valid_o, sample_o, chan_o, exp_data[n_got], exp_chan[n_got]);
            end
            n_got++;
        end
    end

    task automatic slot(input logic b);
        sdata_i = b;
        repeat (4) @(posedge clk);
        bclk_i = 1'b1;
        repeat (4) @(posedge clk);
        bclk_i = 1'b0;
    endtask

    // Send one half-period; when report=1 its expected outcome is queued.
    task automatic send_half(input int f, input logic level, input int nb,
                             input logic [23:0] d, input bit report);
        int          w;
        logic [23:0] e;
        w = wlen(f);
        wclk_i = level;
        if (report) begin
            exp_err[n_exp]  = (nb < hmin(f));
            exp_chan[n_exp] = (f == 1) ? level : ~level;
            if (f >= 2) begin
                e = d;
                for (int i = 0; i < 24; i++) if (i >= w) e[i] = d[w-1];
                exp_data[n_exp] = e;
            end else begin
                exp_data[n_exp] = d;
            end
            n_exp++;
        end
        for (int i = 0; i < nb; i++) begin
            if (f == 0)      slot(i < 24 ? d[23-i] : 1'b1);
            else if (f == 1) slot((i >= 1 && i <= 24) ? d[24-i] : 1'b1);
            else             slot((i >= nb - w) ? d[nb-1-i] : 1'b1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_tests++;
        if (valid_o || frame_err_o || chan_o || sample_o != 24'd0) begin
            n_fail++;
            $display("FAIL R1: valid=%0b err=%0b chan=%0b data=%h, expected all 0",
                     valid_o, frame_err_o, chan_o, sample_o);
        end

        for (int f = 0; f < 6; f++) begin
            int          k;
            logic [31:0] v;
            rst = 1'b1; fmt_i = 3'(f); wclk_i = 1'b0; bclk_i = 1'b0;
            repeat (4) @(posedge clk);
            rst = 1'b0;
            // R6: leading partial half is never reported
            send_half(f, 1'b0, 5, 24'h0, 1'b0);
            k = 0;
            foreach (exp_err[j]) if (j < 3) begin
                int nb;
                nb = (j == 0) ? hmin(f) : (j == 1) ? hmin(f) + 5 : 32;
                for (int h = 0; h < 2; h++) begin
                    v = 32'(k) * 32'h0005A3C7 + 32'h00ABCDE1 * 32'(f + 1) + 32'(h) * 32'h00800000;
                    send_half(f, h == 0 ? 1'b1 : 1'b0, nb, v[23:0], 1'b1);
                    k++;
                end
            end
            // R7: a half one slot short of the minimum
            send_half(f, 1'b1, hmin(f) - 1, 24'h5A5A5A, 1'b1);
            send_half(f, 1'b0, 3, 24'h0, 1'b0);
            repeat (20) @(posedge clk);
            @(negedge clk);
            // R6: number of reports matches expectations
            n_tests++;
            if (n_got != n_exp) begin
                n_fail++;
                $display("FAIL R6 (fmt %0d): %0d reports, expected %0d", f, n_got, n_exp);
                n_got = n_exp;
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule